// File: doc/BRIEF.md
# A/B Double-Buffer Ownership Controller

This block tracks the hand-off of two alternating buffers, A and B, between a host and a DMA engine. There is one set of controls for each of `NCH` independent channels, and each channel serves one transfer direction. Every buffer has an ownership flag: 0 means the host holds it and 1 means the device holds it.

On the transmit side, the host fills a buffer and passes it over with a give strobe. The device then drains the buffers strictly in turn. On the receive side, the host gives empty buffers and the device fills them in the same alternating order. In both directions, a completion returns the buffer to the host and raises a one-cycle interrupt that names the buffer. Address generation and the bus interface belong to neighbouring logic.

The device side behaves as a valid/ready pair. `dev_ready` is the valid: it says that the buffer under the active pointer is device-owned and that the channel is enabled. `dev_done` is the consume strobe, and it only takes effect in a cycle where `dev_ready` is high. When the next buffer in turn is still host-owned, the device waits. It never skips ahead to the other buffer. The host side has no back-pressure. A give for a buffer the device already holds is dropped and reported.

Top module: `dbuf_own_ctrl`

## Requirements
- R1: After reset, every `dev_own` bit is 0 (host), every `active_buf` bit is 0 (buffer A), and `dev_ready`, `done_irq` and `give_err` are all 0.
- R2: A pulse on `host_give[2c+b]` for a buffer that is host-owned sets `dev_own[2c+b]` to 1 at the next clock edge. Bit index b=0 is buffer A and b=1 is buffer B.
- R3: A pulse on `host_give[2c+b]` for a buffer that is already device-owned leaves its ownership unchanged by the give. It produces a one-cycle pulse on `give_err[2c+b]` at the next edge.
- R4: `dev_ready[c]` is combinationally high exactly when `dma_en[c]` is 1 and the buffer selected by `active_buf[c]` is device-owned (0 selects A, 1 selects B).
- R5: `dev_done[c]` while `dev_ready[c]` is high has three effects at the next edge: the active buffer's ownership bit clears to 0, `active_buf[c]` toggles, and `done_irq[2c+b]` for that buffer pulses for exactly one cycle.
- R6: `dev_done[c]` while `dev_ready[c]` is low has no effect. The pointer, the ownership bits and the interrupts stay unchanged, so the device waits on a host-owned buffer instead of moving to the other one.
- R7: Channels are independent. Strobes on one channel never change another channel's outputs.
- R8: With `dma_en[c]` at 0, `dev_ready[c]` stays low and completions are ignored, but host gives are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_en | input | NCH | Per-channel DMA enable |
| host_give | input | 2*NCH | Host hand-over strobes, bit 2c = buffer A, 2c+1 = buffer B |
| dev_done | input | NCH | Device completion strobe for the active buffer |
| active_buf | output | NCH | Active pointer per channel, 0 = A, 1 = B |
| dev_own | output | 2*NCH | Ownership bits, 1 = device-owned |
| dev_ready | output | NCH | Active buffer available to the device |
| done_irq | output | 2*NCH | One-cycle completion pulse per buffer |
| give_err | output | 2*NCH | One-cycle pulse for a give on a device-owned buffer |

## Verification
A corrupted ownership bit shows up on `dev_own` one edge after the stimulus. In the same cycle it also changes `dev_ready`, because the pointer selects that bit. A pointer that toggles at the wrong time shows on `active_buf` at the next edge, and a stalled or misrouted completion shows on `done_irq` at that same edge. Every internal flip-flop reaches a port within one clock, so comparing all outputs after every cycle of a dense stimulus sweep exposes any state fault with no more than one cycle of delay.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
  typedef enum logic {
    BUF_A = 1'b0,
    BUF_B = 1'b1
  } buf_sel_e;

  localparam int NBUF = 2;
endpackage

// File: rtl/dbuf_own_bit.sv
module dbuf_own_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic give,
  input  logic clr,
  output logic own,
  output logic err
);
  logic own_q;
  logic err_q;

  // A give only counts on a host-owned buffer; a clear only arrives while owned.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= give & own_q;
      if (clr)
        own_q <= 1'b0;
      else if (give)
        own_q <= 1'b1;
    end
  end

  assign own = own_q;
  assign err = err_q;

  AST_GIVE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (give && !own) |=> own); // R2
  AST_ERR_ONLY_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    (give && own) |=> err); // R3
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !give |=> !err); // R3
endmodule

// File: rtl/dbuf_chan.sv
module dbuf_chan
  import dbuf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [NBUF-1:0] give,
  input  logic            done,
  output logic            active,
  output logic [NBUF-1:0] own,
  output logic            ready,
  output logic [NBUF-1:0] irq,
  output logic [NBUF-1:0] err
);
  buf_sel_e        ptr_q;
  logic [NBUF-1:0] irq_q;
  logic [NBUF-1:0] clr;
  logic            fire;

  assign ready = en & own[ptr_q];
  assign fire  = done & ready;

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    assign clr[b] = fire & (ptr_q == buf_sel_e'(b));
    dbuf_own_bit u_bit (
      .clk  (clk),
      .rst_n(rst_n),
      .give (give[b]),
      .clr  (clr[b]),
      .own  (own[b]),
      .err  (err[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= BUF_A;
      irq_q <= '0;
    end else begin
      irq_q <= clr;
      if (fire)
        ptr_q <= (ptr_q == BUF_A) ? BUF_B : BUF_A;
    end
  end

  assign active = ptr_q;
  assign irq    = irq_q;

  AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq)); // R5
  AST_PTR_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ready) |=> (active != $past(active))); // R5
  AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && ready) |=> $stable(active)); // R6
  AST_IRQ_A_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] |-> !own[0]); // R5
  AST_IRQ_B_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    irq[1] |-> !own[1]); // R5
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !ready); // R8
endmodule

// File: rtl/dbuf_own_ctrl.sv
module dbuf_own_ctrl
  import dbuf_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0]      dma_en,
  input  logic [NBUF*NCH-1:0] host_give,
  input  logic [NCH-1:0]      dev_done,
  output logic [NCH-1:0]      active_buf,
  output logic [NBUF*NCH-1:0] dev_own,
  output logic [NCH-1:0]      dev_ready,
  output logic [NBUF*NCH-1:0] done_irq,
  output logic [NBUF*NCH-1:0] give_err
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dbuf_chan u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (dma_en[c]),
      .give  (host_give[NBUF*c +: NBUF]),
      .done  (dev_done[c]),
      .active(active_buf[c]),
      .own   (dev_own[NBUF*c +: NBUF]),
      .ready (dev_ready[c]),
      .irq   (done_irq[NBUF*c +: NBUF]),
      .err   (give_err[NBUF*c +: NBUF])
    );
  end

  AST_RESET_FREE: assert property (@(posedge clk)
    !rst_n |=> (dev_own == '0 && active_buf == '0)); // R1
endmodule

// File: tb/dbuf_own_ctrl_bench.sv
`timescale 1ns/1ps
module dbuf_own_ctrl_bench;
  localparam int NCH = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n;
  logic [NCH-1:0]  dma_en;
  logic [2*NCH-1:0] host_give;
  logic [NCH-1:0]  dev_done;
  logic [NCH-1:0]  active_buf;
  logic [2*NCH-1:0] dev_own;
  logic [NCH-1:0]  dev_ready;
  logic [2*NCH-1:0] done_irq;
  logic [2*NCH-1:0] give_err;

  dbuf_own_ctrl #(.NCH(NCH)) u_dbuf_own_ctrl (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .host_give(host_give),
    .dev_done(dev_done), .active_buf(active_buf), .dev_own(dev_own),
    .dev_ready(dev_ready), .done_irq(done_irq), .give_err(give_err)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [1:0] m_own [NCH];
  logic       m_act [NCH];

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Drive one cycle of stimulus at a falling edge and check every output.
  task automatic step(input logic [2*NCH-1:0] g, input logic [NCH-1:0] d, input logic [NCH-1:0] e);
    logic [2*NCH-1:0] x_irq, x_err;
    logic [NCH-1:0]   x_rdy;
    logic [NCH-1:0]   fired;
    x_irq = '0; x_err = '0; x_rdy = '0; fired = '0;
    for (int c = 0; c < NCH; c++) begin
      x_rdy[c] = e[c] & m_own[c][m_act[c]];
      fired[c] = d[c] & x_rdy[c];
      for (int b = 0; b < 2; b++) begin
        x_err[2*c+b] = g[2*c+b] & m_own[c][b];
        x_irq[2*c+b] = fired[c] & (m_act[c] == b[0]);
      end
    end
    host_give = g; dev_done = d; dma_en = e;
    #1;
    chk("R4 ready", 8'(dev_ready), 8'(x_rdy));
    for (int c = 0; c < NCH; c++) begin
      for (int b = 0; b < 2; b++) begin
        m_own[c][b] = (m_own[c][b] & ~(fired[c] & (m_act[c] == b[0])))
                    | (g[2*c+b] & ~m_own[c][b]);
      end
      m_act[c] = m_act[c] ^ fired[c];
    end
    @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      chk(fired[c] ? "R5 own" : "R2 own", 8'(dev_own[2*c +: 2]), 8'(m_own[c]));
      chk(fired[c] ? "R5 active" : "R6 active", 8'(active_buf[c]), 8'(m_act[c]));
    end
    chk("R5 irq", 8'(done_irq), 8'(x_irq));
    chk("R3 err", 8'(give_err), 8'(x_err));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R1 watchdog got=hang exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dma_en = '0; host_give = '0; dev_done = '0;
    for (int c = 0; c < NCH; c++) begin m_own[c] = 2'b00; m_act[c] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 own", 8'(dev_own), 8'h0);
    chk("R1 active", 8'(active_buf), 8'h0);
    chk("R1 ready", 8'(dev_ready), 8'h0);
    chk("R1 irq", 8'(done_irq), 8'h0);
    chk("R1 err", 8'(give_err), 8'h0);
    @(negedge clk);

    // R7: give on channel 0 only
    step(4'b0001, 2'b00, 2'b11);
    chk("R7 other channel own", 8'(dev_own[3:2]), 8'h0);
    chk("R7 other channel ready", 8'(dev_ready[1]), 8'h0);
    // R8: disabled channel accepts give but ignores done
    step(4'b0100, 2'b10, 2'b00);
    chk("R8 give accepted", 8'(dev_own[3:2]), 8'h1);
    chk("R8 ready low", 8'(dev_ready[1]), 8'h0);
    step(4'b0000, 2'b10, 2'b01);
    chk("R8 done ignored", 8'(active_buf[1]), 8'h0);
    chk("R8 no irq", 8'(done_irq[3:2]), 8'h0);
    // R6: pointer on B while B is host-owned: done must stall
    step(4'b0000, 2'b01, 2'b01);
    chk("R5 pointer on B", 8'(active_buf[0]), 8'h1);
    step(4'b0001, 2'b01, 2'b01);
    chk("R6 stall on host-owned B", 8'(active_buf[0]), 8'h1);
    chk("R6 A kept", 8'(dev_own[1:0]), 8'h1);

    // Dense sweep of all per-cycle input combinations in varied orders.
    for (int p = 0; p < 6; p++) begin
      for (int i = 0; i < 256; i++) begin
        logic [7:0] v;
        v = 8'((i * 97 + p * 31) % 256);
        step(v[3:0], v[5:4], v[7:6]);
      end
    end
    step(4'b0000, 2'b00, 2'b00);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule